// File: doc/BRIEF.md
# Stereo Second-Order Sigma-Delta Modulator

This block turns two streams of oversampled signed PCM words, one for the left channel and one for the right, into two 1-bit pulse-density streams for a single-bit audio DAC. Each channel is a loop of two cascaded integrators feeding a sign quantizer. The quantizer picks plus or minus full scale, and that value is fed back into both integrators. The signal passes through the loop unchanged while quantization noise is pushed towards high frequencies with a second-order shape, so that an analog low-pass filter can recover the audio.

A single clock enable, `mod_en`, advances both channels together. The surrounding clock logic pulses it at 192 times the active audio sample rate. In double-speed operation the enable simply runs twice as often, so the ratio to the sample rate does not change. The interpolator holds each input word constant between its own updates. The integrators are `GUARD_W` bits wider than the input (at least 4) and clamp at their limits instead of wrapping. Each channel has its own synchronous clear, and a global synchronous reset clears both.

Top module: `sdm2_stereo`

## Requirements
- R1: On any clock edge with `rst_n` low, both channels' integrators clear to zero, and both outputs then read 1.
- R2: A channel's output and integrators change only at an edge where `mod_en` is high or where that channel is being cleared. At every other edge they hold.
- R3: Both channels share `mod_en` and update at the same edge, each using only its own input.
- R4: Let FS = 2^(DATA_W-1). The output bit is 1 when the second integrator s2 is zero or positive, which selects feedback f = +FS, and 0 when s2 is negative, which selects f = -FS. At an enabled edge the first integrator becomes s1' = clamp(s1 + x - f), and after that s2' = clamp(s2 + s1' - f). The new s1' is used in the s2 update.
- R5: clamp() limits each integrator to the range -2^(ACC_W-1) to 2^(ACC_W-1)-1, with ACC_W = DATA_W + GUARD_W. A result outside that range sticks at the nearer limit and never wraps to the opposite sign.
- R6: After a clear, a zero input produces the output sequence 1,0,0,1 repeating from the first output onward, a ones density of exactly one half.
- R7: `chan_clr[0]` clears only the left channel and `chan_clr[1]` clears only the right channel. A clear takes priority over an update at the same edge.
- R8: For a constant input x with |x| <= FS/2, the count of ones over 4096 consecutive updates from a clear equals 4096*(x/FS+1)/2 within ±1%.
- R9: Input words are 16-bit two's complement and are sign-extended, so negative inputs drive the loop as negative values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Synchronous active-low reset for both channels |
| mod_en | input | 1 | Shared update enable, pulsed at 192x the sample rate |
| chan_clr | input | 2 | Per-channel synchronous clear; bit 0 is left, bit 1 is right |
| pcm_l | input | DATA_W | Left signed PCM sample |
| pcm_r | input | DATA_W | Right signed PCM sample |
| bit_l | output | 1 | Left 1-bit modulator output |
| bit_r | output | 1 | Right 1-bit modulator output |

## Verification
Two events can land on the same edge: a per-channel clear and a shared enable update. The bench raises `chan_clr` for one channel while `mod_en` is high. The cleared channel must restart its 1,0,0,1 zero-input pattern, and the other channel must keep following its own trajectory without a break. Saturation and the sign decision can also meet in one step. A full-scale input held for thousands of updates drives both integrators into their limits, and every bit is judged against an independent bench model of the clamped recurrence.

// File: rtl/sdm2_pkg.sv
package sdm2_pkg;
    // Feedback polarity chosen by the quantizer.
    typedef enum logic {
        FB_MINUS = 1'b0,
        FB_PLUS  = 1'b1
    } fb_pol_e;

    localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/sdm2_sat3.sv
// Saturating a + b - c on ACC_W-bit signed operands.
module sdm2_sat3 #(
    parameter int unsigned W = 20
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    input  logic signed [W-1:0] c,
    output logic signed [W-1:0] y
);
    localparam int unsigned EW = W + 2;
    localparam logic signed [EW-1:0] MAXV = {3'b000, {(W-1){1'b1}}};
    localparam logic signed [EW-1:0] MINV = {3'b111, {(W-1){1'b0}}};

    logic signed [EW-1:0] sum;

    always_comb begin
        sum = $signed({{2{a[W-1]}}, a}) + $signed({{2{b[W-1]}}, b})
            - $signed({{2{c[W-1]}}, c});
        if (sum > MAXV) begin
            y = MAXV[W-1:0];
        end else if (sum < MINV) begin
            y = MINV[W-1:0];
        end else begin
            y = sum[W-1:0];
        end
    end
endmodule

// File: rtl/sdm2_chan.sv
// One channel: two clamped integrators and a sign quantizer.
module sdm2_chan
    import sdm2_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned GUARD_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     clr,
    input  logic signed [DATA_W-1:0] pcm,
    output logic                     bit_o
);
    localparam int unsigned ACC_W = DATA_W + GUARD_W;
    localparam logic signed [ACC_W-1:0] FB_MAG = ACC_W'(1) << (DATA_W - 1);
    localparam logic signed [ACC_W-1:0] QTR    = ACC_W'(1) << (ACC_W - 2);
    localparam logic signed [ACC_W-1:0] TRIP   = 3 * FB_MAG;

    typedef struct packed {
        logic signed [ACC_W-1:0] s1;
        logic signed [ACC_W-1:0] s2;
    } state_t;

    state_t                  st_d, st_q;
    fb_pol_e                 pol;
    logic signed [ACC_W-1:0] fb;
    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] s1_sum;
    logic signed [ACC_W-1:0] s2_sum;

    assign x_ext = {{GUARD_W{pcm[DATA_W-1]}}, pcm};
    assign pol   = st_q.s2[ACC_W-1] ? FB_MINUS : FB_PLUS;
    assign fb    = (pol == FB_PLUS) ? FB_MAG : -FB_MAG;
    assign bit_o = (pol == FB_PLUS);

    sdm2_sat3 #(.W(ACC_W)) u_int1 (
        .a (st_q.s1),
        .b (x_ext),
        .c (fb),
        .y (s1_sum)
    );

    sdm2_sat3 #(.W(ACC_W)) u_int2 (
        .a (st_q.s2),
        .b (s1_sum),
        .c (fb),
        .y (s2_sum)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_n || clr) begin
            st_d = '0;
        end else if (en) begin
            st_d.s1 = s1_sum;
            st_d.s2 = s2_sum;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R2: no enable and no clear means the state holds.
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(st_q));

    // R7: a clear empties both integrators.
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q == '0));

    // R5: the first integrator cannot jump from a large value to the opposite sign.
    a_r5_s1_no_wrap_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && st_q.s1 >= QTR) |=> !st_q.s1[ACC_W-1]);
    a_r5_s1_no_wrap_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && st_q.s1 < -QTR) |=> st_q.s1[ACC_W-1]);

    // R5: a step that is known to be upward or downward keeps its direction at the limit.
    a_r5_s2_up: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !st_q.s2[ACC_W-1] && st_q.s1 >= TRIP)
        |=> st_q.s2 >= $past(st_q.s2));
    a_r5_s2_down: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && st_q.s2[ACC_W-1] && st_q.s1 <= -TRIP)
        |=> st_q.s2 <= $past(st_q.s2));
endmodule

// File: rtl/sdm2_stereo.sv
// Two lock-stepped second-order modulators.
module sdm2_stereo
    import sdm2_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned GUARD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_en,
    input  logic [1:0]        chan_clr,
    input  logic [DATA_W-1:0] pcm_l,
    input  logic [DATA_W-1:0] pcm_r,
    output logic              bit_l,
    output logic              bit_r
);
    logic signed [DATA_W-1:0] pcm_a [NUM_CH];
    logic                     bit_a [NUM_CH];

    assign pcm_a[0] = $signed(pcm_l);
    assign pcm_a[1] = $signed(pcm_r);

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            sdm2_chan #(
                .DATA_W  (DATA_W),
                .GUARD_W (GUARD_W)
            ) u_chan (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (mod_en),
                .clr   (chan_clr[c]),
                .pcm   (pcm_a[c]),
                .bit_o (bit_a[c])
            );
        end
    endgenerate

    assign bit_l = bit_a[0];
    assign bit_r = bit_a[1];

    // R3: without the shared enable and without a clear, neither output moves.
    a_r3_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_en && chan_clr == 2'b00) |=> $stable({bit_l, bit_r}));

    // R1: the edge after a reset shows both outputs high.
    a_r1_reset_out: assert property (@(posedge clk)
        !rst_n |=> (bit_l && bit_r));
endmodule

// File: tb/tb_sdm2_stereo.sv
module tb_sdm2_stereo;
    localparam int CLK_P = 10;
    localparam int DW    = 16;
    localparam int GW    = 4;
    localparam int AW    = DW + GW;
    localparam longint FS   = 64'sd1 <<< (DW - 1);
    localparam longint AMAX = (64'sd1 <<< (AW - 1)) - 1;
    localparam longint AMIN = -(64'sd1 <<< (AW - 1));

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mod_en = 1'b0;
    logic [1:0]    chan_clr = 2'b00;
    logic [DW-1:0] pcm_l = '0;
    logic [DW-1:0] pcm_r = '0;
    logic          bit_l, bit_r;

    sdm2_stereo #(.DATA_W(DW), .GUARD_W(GW)) dut (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .chan_clr(chan_clr),
        .pcm_l(pcm_l), .pcm_r(pcm_r), .bit_l(bit_l), .bit_r(bit_r)
    );

    always #(CLK_P/2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    logic [1:0] exp_q [$];
    string      tag_q [$];
    longint     m1 [2];
    longint     m2 [2];
    int ones_l = 0, ones_r = 0;

    function automatic longint clampv(input longint v);
        if (v > AMAX) return AMAX;
        if (v < AMIN) return AMIN;
        return v;
    endfunction

    // Driver: applies one cycle of stimulus and queues the outputs expected after the edge.
    task automatic cycle(input int xl, input int xr, input bit en,
                         input bit [1:0] clr, input bit rst, input string tag);
        @(negedge clk);
        rst_n    = ~rst;
        mod_en   = en;
        chan_clr = clr;
        pcm_l    = xl[DW-1:0];
        pcm_r    = xr[DW-1:0];
        for (int c = 0; c < 2; c++) begin
            longint x, f;
            x = (c == 0) ? longint'(xl) : longint'(xr);
            if (rst || clr[c]) begin
                m1[c] = 0;
                m2[c] = 0;
            end else if (en) begin
                f = (m2[c] >= 0) ? FS : -FS;
                m1[c] = clampv(m1[c] + x - f);
                m2[c] = clampv(m2[c] + m1[c] - f);
            end
        end
        exp_q.push_back({m2[0] >= 0, m2[1] >= 0});
        tag_q.push_back(tag);
    endtask

    // Monitor: compares each produced output against the queue head.
    always begin
        logic [1:0] e;
        string t;
        @(posedge clk);
        #(CLK_P/4);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({bit_l, bit_r} !== e) begin
                errors++;
                $display("FAIL %s: got %b expected %b at %0t", t, {bit_l, bit_r}, e, $time);
            end
            if (t == "R8") begin
                ones_l += int'(bit_l);
                ones_r += int'(bit_r);
            end
        end
    end

    task automatic check_range(input string tag, input int got, input int lo, input int hi);
        checks++;
        if (got < lo || got > hi) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d..%0d", tag, got, lo, hi);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        m1[0] = 0; m1[1] = 0; m2[0] = 0; m2[1] = 0;
        // R1: reset state
        for (int i = 0; i < 3; i++) cycle(1234, -999, 1'b1, 2'b00, 1'b1, "R1");
        // R6: zero input after reset gives 1,0,0,1 repeating
        for (int i = 0; i < 16; i++) cycle(0, 0, 1'b1, 2'b00, 1'b0, "R6");
        // R4 / R9: distinct random inputs per channel, negative values included
        for (int i = 0; i < 400; i++)
            cycle(int'($urandom_range(32767)) - 16384, -int'($urandom_range(16000)),
                  1'b1, 2'b00, 1'b0, "R4_R9");
        // R2: sparse enable with changing inputs
        for (int i = 0; i < 300; i++)
            cycle(int'($urandom_range(20000)) - 10000, int'($urandom_range(20000)) - 10000,
                  (i % 3) == 0, 2'b00, 1'b0, "R2");
        // R3: different inputs, shared enable
        for (int i = 0; i < 200; i++)
            cycle(12000, -12000, 1'b1, 2'b00, 1'b0, "R3");
        // R7: left clear coinciding with enable, then right clear alone
        cycle(5000, 7000, 1'b1, 2'b01, 1'b0, "R7");
        for (int i = 0; i < 8; i++) cycle(0, 7000, 1'b1, 2'b00, 1'b0, "R7");
        cycle(0, 7000, 1'b0, 2'b10, 1'b0, "R7");
        for (int i = 0; i < 8; i++) cycle(-3000, 0, 1'b1, 2'b00, 1'b0, "R7");
        // R5: full-scale overload drives integrators to their limits
        for (int i = 0; i < 3000; i++) cycle(32767, -32768, 1'b1, 2'b00, 1'b0, "R5");
        for (int i = 0; i < 3000; i++) cycle(-32768, 32767, 1'b1, 2'b00, 1'b0, "R5");
        // R8: DC density from a clear
        cycle(0, 0, 1'b0, 2'b11, 1'b0, "R7");
        ones_l = 0;
        ones_r = 0;
        for (int i = 0; i < 4096; i++) cycle(8192, -16384, 1'b1, 2'b00, 1'b0, "R8");
        for (int i = 0; i < 3; i++) cycle(0, 0, 1'b0, 2'b00, 1'b0, "R2");
        wait (exp_q.size() == 0);
        @(negedge clk);
        check_range("R8 left density", ones_l, 2560 - 41, 2560 + 41);
        check_range("R8 right density", ones_r, 1024 - 41, 1024 + 41);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule